// File: doc/BRIEF.md
# Short-Lived Result Register File

This block is a small side register file that sits next to a reorder buffer (ROB) and an architectural register file (ARF) in an out-of-order core. A result counts as short-lived when a younger instruction has already renamed its destination register by the time the result reaches writeback. Such a result is captured here instead of being written into the ROB. When it is safely dead it is dropped without ever reaching the ARF. Each entry is keyed by the ROB slot of the instruction that produced it. Each entry also carries two branch tags. The first tag belongs to the branch that precedes the renaming instruction. The second belongs to the branch that precedes the producing instruction.

Entries leave the file in one of four ways:
- The renaming instruction commits and names the producer's slot as its flush slot.
- The producing instruction is squashed by a mispredict. The entry is then discarded.
- The renaming instruction is squashed. The value is then spilled back to the ROB or the ARF.
- A precise interrupt arrives. Every live value is then drained to the ARF.

Spills go out through a single port, one per cycle. While spills are pending, `busy` is high. During that time the core holds commit, and the file accepts no new capture.

Top module: `slr_file`

## Requirements
- R1: A writeback request is captured, and `cap_taken` is high in the same cycle, when all of these hold: a free entry exists, no valid entry holds the same ROB slot, `busy` is low, and neither `mis_valid` nor `intr_req` is high. A captured result goes into the lowest-numbered free entry.
- R2: A writeback whose ROB slot is already held by a valid entry is refused (`cap_taken` low), and the file is left unchanged.
- R3: When every entry is valid, a writeback is refused.
- R4: `cmt_skip_arf` is high in a cycle with `cmt_valid` high, `busy` low and an entry allocated for `cmt_rob`; otherwise it is low. A commit clears that slot's uncommitted mark.
- R5: A commit with `cmt_flush_valid` frees the entry whose slot is `cmt_flush_idx` only if that slot is allocated and its producer has already committed. Otherwise the entry stays.
- R6: On `mis_valid`, an entry whose producer tag equals `mis_tag` is invalidated without any spill. This rule takes priority over a match on the renamer tag.
- R7: On `mis_valid`, an entry whose renamer tag equals `mis_tag` is spilled. The spill goes to the ROB (`spill_to_rob`=1, at `spill_rob`) while its producer slot is uncommitted. Otherwise it goes to the ARF (`spill_to_rob`=0, at `spill_areg`).
- R8: Pending spills leave one per cycle, in ascending entry order. `busy` equals `spill_valid` and stays high until the last pending spill has left.
- R9: On `intr_req`, every valid entry is spilled to the ARF (`spill_to_rob`=0). Afterwards the file is empty.
- R10: While `busy` is high, writeback requests and commits are ignored: `cap_taken` and `cmt_skip_arf` stay low.
- R11: After reset, no entry is valid, no slot is allocated, and `busy`, `spill_valid` and `cap_taken` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Short-lived writeback request |
| cap_rob | input | ROB_W | ROB slot of the producer |
| cap_areg | input | AREG_W | Destination architectural register |
| cap_data | input | DATA_W | Result value |
| cap_bt1 | input | TAG_W | Tag of the branch before the renaming instruction |
| cap_bt2 | input | TAG_W | Tag of the branch before the producer |
| cap_taken | output | 1 | Writeback captured this cycle |
| cmt_valid | input | 1 | A ROB slot commits |
| cmt_rob | input | ROB_W | Committing ROB slot |
| cmt_flush_valid | input | 1 | The committing instruction carries a flush slot |
| cmt_flush_idx | input | ROB_W | Flush slot (the producer it renamed over) |
| cmt_skip_arf | output | 1 | Committing value lives here; skip the ARF copy |
| mis_valid | input | 1 | Branch mispredict broadcast |
| mis_tag | input | TAG_W | Tag of the mispredicted branch |
| intr_req | input | 1 | Precise-interrupt drain request |
| spill_valid | output | 1 | Spill port carries a value |
| spill_to_rob | output | 1 | 1: write to ROB slot; 0: write to ARF register |
| spill_rob | output | ROB_W | ROB slot of the spilled value |
| spill_areg | output | AREG_W | Architectural register of the spilled value |
| spill_data | output | DATA_W | Spilled value |
| busy | output | 1 | Spills pending; commit must stall |

## Verification
The assertions check the per-cycle invariants on every cycle:
- No capture happens while busy.
- A capture never duplicates a slot, and it marks its slot allocated one cycle later.
- An uncommitted mark never exists without an allocation.
- Drain-mode spills always target the ARF.
- `busy` only drops after a spill.

Other properties depend on history and can only be shown by the bench's scenarios, which run against the lockstep reference model:
- Whether a flush removal is legal, which depends on the producer having committed earlier.
- The priority of the producer tag over the renamer tag.
- The ROB-versus-ARF destination chosen for each spill.
- The ascending order of serialized spills.

// File: rtl/slr_pkg.sv
package slr_pkg;

  // Action taken on one entry by a mispredict broadcast.
  typedef enum logic [1:0] {
    MIS_NONE  = 2'd0,
    MIS_KILL  = 2'd1,
    MIS_SPILL = 2'd2
  } mis_act_e;

  // A producer squash outranks a renamer squash.
  function automatic mis_act_e mis_classify(input logic live,
                                            input logic prod_hit,
                                            input logic ren_hit);
    if (!live)         return MIS_NONE;
    else if (prod_hit) return MIS_KILL;
    else if (ren_hit)  return MIS_SPILL;
    else               return MIS_NONE;
  endfunction

endpackage

// File: rtl/slr_first_set.sv
module slr_first_set #(
  parameter int N  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/slr_slot_track.sv
module slr_slot_track #(
  parameter int ROB_DEPTH = 64,
  localparam int ROB_W = $clog2(ROB_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [ROB_W-1:0]     set_idx,
  input  logic                 commit_en,
  input  logic [ROB_W-1:0]     commit_idx,
  input  logic [ROB_DEPTH-1:0] drop_vec,
  output logic [ROB_DEPTH-1:0] alloc_vec,
  output logic [ROB_DEPTH-1:0] uncmt_vec
);

  logic [ROB_DEPTH-1:0] alloc_q, alloc_d;
  logic [ROB_DEPTH-1:0] uncmt_q, uncmt_d;
  logic [ROB_DEPTH-1:0] set_dec, cmt_dec;

  always_comb begin
    set_dec = '0;
    cmt_dec = '0;
    if (set_en)    set_dec[set_idx]    = 1'b1;
    if (commit_en) cmt_dec[commit_idx] = 1'b1;
    alloc_d = (alloc_q & ~drop_vec) | set_dec;
    uncmt_d = (uncmt_q & ~drop_vec & ~cmt_dec) | set_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_q <= '0;
      uncmt_q <= '0;
    end else begin
      alloc_q <= alloc_d;
      uncmt_q <= uncmt_d;
    end
  end

  assign alloc_vec = alloc_q;
  assign uncmt_vec = uncmt_q;

endmodule

// File: rtl/slr_file.sv
module slr_file #(
  parameter int ENTRIES   = 32,
  parameter int ROB_DEPTH = 64,
  parameter int AREG_W    = 5,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 4,
  localparam int ROB_W    = $clog2(ROB_DEPTH),
  localparam int EIDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [ROB_W-1:0]  cap_rob,
  input  logic [AREG_W-1:0] cap_areg,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [TAG_W-1:0]  cap_bt1,
  input  logic [TAG_W-1:0]  cap_bt2,
  output logic              cap_taken,
  input  logic              cmt_valid,
  input  logic [ROB_W-1:0]  cmt_rob,
  input  logic              cmt_flush_valid,
  input  logic [ROB_W-1:0]  cmt_flush_idx,
  output logic              cmt_skip_arf,
  input  logic              mis_valid,
  input  logic [TAG_W-1:0]  mis_tag,
  input  logic              intr_req,
  output logic              spill_valid,
  output logic              spill_to_rob,
  output logic [ROB_W-1:0]  spill_rob,
  output logic [AREG_W-1:0] spill_areg,
  output logic [DATA_W-1:0] spill_data,
  output logic              busy
);
  import slr_pkg::*;

  // Entry state: control bits are reset, payload is not.
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] pend_q, pend_d;
  logic               drain_q, drain_d;
  logic [ROB_W-1:0]   rob_q  [ENTRIES];
  logic [AREG_W-1:0]  areg_q [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [TAG_W-1:0]   bt1_q  [ENTRIES];
  logic [TAG_W-1:0]   bt2_q  [ENTRIES];

  logic [ENTRIES-1:0] kill, flush_hit, mis_kill, mis_spill, wr_en;
  logic [ROB_DEPTH-1:0] alloc_vec, uncmt_vec, drop_vec;
  logic               free_found, spill_found;
  logic [EIDX_W-1:0]  free_idx, spill_idx;
  logic               flush_ok, commit_en;

  slr_first_set #(.N(ENTRIES)) u_free (
    .req   (~valid_q),
    .found (free_found),
    .idx   (free_idx)
  );

  slr_first_set #(.N(ENTRIES)) u_spill (
    .req   (pend_q),
    .found (spill_found),
    .idx   (spill_idx)
  );

  slr_slot_track #(.ROB_DEPTH(ROB_DEPTH)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (cap_taken),
    .set_idx    (cap_rob),
    .commit_en  (commit_en),
    .commit_idx (cmt_rob),
    .drop_vec   (drop_vec),
    .alloc_vec  (alloc_vec),
    .uncmt_vec  (uncmt_vec)
  );

  // Per-entry match logic.
  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      mis_act_e act;
      assign act = mis_classify(valid_q[e] & mis_valid,
                                bt2_q[e] == mis_tag,
                                bt1_q[e] == mis_tag);
      assign mis_kill[e]  = (act == MIS_KILL);
      assign mis_spill[e] = (act == MIS_SPILL);
      assign flush_hit[e] = valid_q[e] && (rob_q[e] == cmt_flush_idx);
      assign wr_en[e]     = cap_taken && (free_idx == EIDX_W'(e));

      always_ff @(posedge clk) begin
        if (wr_en[e]) begin
          rob_q[e]  <= cap_rob;
          areg_q[e] <= cap_areg;
          data_q[e] <= cap_data;
          bt1_q[e]  <= cap_bt1;
          bt2_q[e]  <= cap_bt2;
        end
      end
    end
  endgenerate

  assign busy      = spill_found;
  assign commit_en = cmt_valid && !busy;
  assign flush_ok  = commit_en && cmt_flush_valid &&
                     alloc_vec[cmt_flush_idx] && !uncmt_vec[cmt_flush_idx];
  assign cap_taken = cap_valid && !busy && !mis_valid && !intr_req &&
                     free_found && !alloc_vec[cap_rob];
  assign cmt_skip_arf = commit_en && alloc_vec[cmt_rob];

  // Next state of the entry control bits.
  always_comb begin
    kill = mis_kill;
    if (busy)     kill[spill_idx] = 1'b1;
    if (flush_ok) kill = kill | flush_hit;

    pend_d = pend_q | mis_spill;
    if (intr_req) pend_d = pend_d | valid_q;
    pend_d  = pend_d & ~kill;
    valid_d = valid_q & ~kill;
    if (cap_taken) valid_d[free_idx] = 1'b1;

    if (intr_req)     drain_d = 1'b1;
    else if (~|pend_d) drain_d = 1'b0;
    else              drain_d = drain_q;

    drop_vec = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (kill[e]) drop_vec[rob_q[e]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      pend_q  <= '0;
      drain_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      pend_q  <= pend_d;
      drain_q <= drain_d;
    end
  end

  // Single serialized spill port.
  assign spill_valid  = busy;
  assign spill_rob    = rob_q[spill_idx];
  assign spill_areg   = areg_q[spill_idx];
  assign spill_data   = data_q[spill_idx];
  assign spill_to_rob = !drain_q && uncmt_vec[rob_q[spill_idx]];

endmodule

// File: rtl/slr_file_chk.sv
module slr_file_chk #(
  parameter int ROB_DEPTH = 64,
  localparam int ROB_W = $clog2(ROB_DEPTH)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cap_valid,
  input logic [ROB_W-1:0]     cap_rob,
  input logic                 cap_taken,
  input logic                 cmt_valid,
  input logic                 cmt_skip_arf,
  input logic                 busy,
  input logic                 spill_valid,
  input logic                 spill_to_rob,
  input logic                 drain,
  input logic [ROB_DEPTH-1:0] alloc_vec,
  input logic [ROB_DEPTH-1:0] uncmt_vec
);

  a_r1_cap_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cap_taken |-> cap_valid);

  a_r1_cap_marks_slot: assert property (@(posedge clk) disable iff (!rst_n)
    cap_taken |=> alloc_vec[$past(cap_rob)]);

  a_r2_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
    cap_taken |-> !alloc_vec[cap_rob]);

  a_r4_skip_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_skip_arf |-> cmt_valid);

  a_r5_uncmt_implies_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (uncmt_vec & ~alloc_vec) == '0);

  a_r8_busy_ends_after_spill: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(spill_valid));

  a_r9_drain_to_arf: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && spill_valid) |-> !spill_to_rob);

  a_r10_no_cap_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cap_taken && !cmt_skip_arf);

endmodule

bind slr_file slr_file_chk #(.ROB_DEPTH(ROB_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cap_valid    (cap_valid),
  .cap_rob      (cap_rob),
  .cap_taken    (cap_taken),
  .cmt_valid    (cmt_valid),
  .cmt_skip_arf (cmt_skip_arf),
  .busy         (busy),
  .spill_valid  (spill_valid),
  .spill_to_rob (spill_to_rob),
  .drain        (drain_q),
  .alloc_vec    (alloc_vec),
  .uncmt_vec    (uncmt_vec)
);

// File: tb/tb_slr_file.sv
module tb_slr_file;
  localparam int E  = 4;
  localparam int RD = 16;
  localparam int RW = 4;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cap_valid, cmt_valid, cmt_flush_valid, mis_valid, intr_req;
  logic [RW-1:0] cap_rob, cmt_rob, cmt_flush_idx;
  logic [AW-1:0] cap_areg;
  logic [DW-1:0] cap_data;
  logic [TW-1:0] cap_bt1, cap_bt2, mis_tag;
  logic cap_taken, cmt_skip_arf, spill_valid, spill_to_rob, busy;
  logic [RW-1:0] spill_rob;
  logic [AW-1:0] spill_areg;
  logic [DW-1:0] spill_data;

  always #10 clk = ~clk;  // 50 MHz

  slr_file #(.ENTRIES(E), .ROB_DEPTH(RD), .AREG_W(AW), .DATA_W(DW), .TAG_W(TW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cap_valid(cap_valid), .cap_rob(cap_rob), .cap_areg(cap_areg), .cap_data(cap_data),
    .cap_bt1(cap_bt1), .cap_bt2(cap_bt2), .cap_taken(cap_taken),
    .cmt_valid(cmt_valid), .cmt_rob(cmt_rob), .cmt_flush_valid(cmt_flush_valid),
    .cmt_flush_idx(cmt_flush_idx), .cmt_skip_arf(cmt_skip_arf),
    .mis_valid(mis_valid), .mis_tag(mis_tag), .intr_req(intr_req),
    .spill_valid(spill_valid), .spill_to_rob(spill_to_rob), .spill_rob(spill_rob),
    .spill_areg(spill_areg), .spill_data(spill_data), .busy(busy)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R11";

  // Behavioural reference state.
  bit m_v[E], m_p[E], m_al[RD], m_uc[RD], m_dr;
  int m_rob[E], m_areg[E], m_data[E], m_b1[E], m_b2[E];

  // Outputs sampled in the last step.
  bit o_cap, o_skip, o_busy, o_sv, o_tor;
  int o_srob, o_sareg, o_sdata;

  task automatic ck(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int first_pend();
    for (int e = 0; e < E; e++) if (m_p[e]) return e;
    return -1;
  endfunction

  function automatic int first_free();
    for (int e = 0; e < E; e++) if (!m_v[e]) return e;
    return -1;
  endfunction

  task automatic step();
    int sp, fr;
    bit e_cap, e_skip, e_busy;
    bit kill[E], newp[E];
    #1;
    sp = first_pend();
    fr = first_free();
    e_busy = (sp >= 0);
    e_cap  = cap_valid && !e_busy && !mis_valid && !intr_req && fr >= 0 && !m_al[cap_rob];
    e_skip = cmt_valid && !e_busy && m_al[cmt_rob];
    o_cap = cap_taken; o_skip = cmt_skip_arf; o_busy = busy; o_sv = spill_valid;
    o_tor = spill_to_rob; o_srob = spill_rob; o_sareg = spill_areg; o_sdata = spill_data;
    ck(cur_tag, "cap_taken (R1)", cap_taken, e_cap);
    ck(cur_tag, "cmt_skip_arf (R4)", cmt_skip_arf, e_skip);
    ck(cur_tag, "busy (R8)", busy, e_busy);
    ck(cur_tag, "spill_valid (R8)", spill_valid, e_busy);
    if (e_busy) begin
      ck(cur_tag, "spill_to_rob (R7)", spill_to_rob, !m_dr && m_uc[m_rob[sp]]);
      ck(cur_tag, "spill_rob (R7)", spill_rob, m_rob[sp]);
      ck(cur_tag, "spill_areg (R7)", spill_areg, m_areg[sp]);
      ck(cur_tag, "spill_data (R7)", spill_data, m_data[sp]);
    end
    @(posedge clk);
    for (int e = 0; e < E; e++) begin kill[e] = 0; newp[e] = 0; end
    if (e_busy) kill[sp] = 1;
    if (cmt_valid && !e_busy && cmt_flush_valid && m_al[cmt_flush_idx] && !m_uc[cmt_flush_idx])
      for (int e = 0; e < E; e++) if (m_v[e] && m_rob[e] == cmt_flush_idx) kill[e] = 1;
    if (mis_valid)
      for (int e = 0; e < E; e++) if (m_v[e]) begin
        if (m_b2[e] == mis_tag) kill[e] = 1;
        else if (m_b1[e] == mis_tag) newp[e] = 1;
      end
    if (intr_req) for (int e = 0; e < E; e++) if (m_v[e]) newp[e] = 1;
    if (cmt_valid && !e_busy) m_uc[cmt_rob] = 0;
    for (int e = 0; e < E; e++) begin
      if (kill[e]) begin
        m_al[m_rob[e]] = 0; m_uc[m_rob[e]] = 0; m_v[e] = 0; m_p[e] = 0;
      end else if (newp[e]) m_p[e] = 1;
    end
    if (e_cap) begin
      m_v[fr] = 1; m_rob[fr] = cap_rob; m_areg[fr] = cap_areg; m_data[fr] = cap_data;
      m_b1[fr] = cap_bt1; m_b2[fr] = cap_bt2; m_al[cap_rob] = 1; m_uc[cap_rob] = 1;
    end
    if (intr_req) m_dr = 1;
    else if (first_pend() < 0) m_dr = 0;
    @(negedge clk);
  endtask

  task automatic idle_in();
    cap_valid = 0; cmt_valid = 0; cmt_flush_valid = 0; mis_valid = 0; intr_req = 0;
    cap_rob = 0; cap_areg = 0; cap_data = 0; cap_bt1 = 0; cap_bt2 = 0;
    cmt_rob = 0; cmt_flush_idx = 0; mis_tag = 0;
  endtask

  task automatic cap(int rob, int areg, int data, int b1, int b2);
    idle_in();
    cap_valid = 1; cap_rob = RW'(rob); cap_areg = AW'(areg); cap_data = DW'(data);
    cap_bt1 = TW'(b1); cap_bt2 = TW'(b2);
    step();
  endtask

  task automatic commit(int rob, bit fv, int fi);
    idle_in();
    cmt_valid = 1; cmt_rob = RW'(rob); cmt_flush_valid = fv; cmt_flush_idx = RW'(fi);
    step();
  endtask

  task automatic mispredict(int tag);
    idle_in(); mis_valid = 1; mis_tag = TW'(tag); step();
  endtask

  task automatic nop();
    idle_in(); step();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < E; e++) begin m_v[e] = 0; m_p[e] = 0; end
    for (int s = 0; s < RD; s++) begin m_al[s] = 0; m_uc[s] = 0; end
    m_dr = 0;
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_tag = "R11";
    nop();
    ck("R11", "busy after reset", o_busy, 0);
    ck("R11", "spill_valid after reset", o_sv, 0);
    commit(2, 0, 0);
    ck("R11", "no slot allocated after reset", o_skip, 0);

    cur_tag = "R1";
    cap(3, 1, 'h11, 1, 0);
    ck("R1", "first capture", o_cap, 1);
    cur_tag = "R2";
    cap(3, 9, 'h99, 1, 0);
    ck("R2", "duplicate slot refused", o_cap, 0);

    cur_tag = "R3";
    cap(5, 2, 'h22, 2, 0);
    cap(6, 3, 'h33, 3, 6);
    cap(7, 4, 'h44, 1, 7);
    cap(8, 5, 'h55, 4, 0);
    ck("R3", "full file refuses", o_cap, 0);

    cur_tag = "R4";
    commit(3, 0, 0);
    ck("R4", "commit of held slot skips ARF", o_skip, 1);
    commit(9, 0, 0);
    ck("R4", "commit of other slot copies", o_skip, 0);

    cur_tag = "R5";
    commit(10, 1, 5);
    cap(8, 5, 'h55, 4, 0);
    ck("R5", "producer uncommitted: entry kept", o_cap, 0);
    commit(11, 1, 3);
    cap(8, 5, 'h55, 4, 0);
    ck("R5", "producer committed: entry freed", o_cap, 1);

    cur_tag = "R6";
    mispredict(6);
    ck("R6", "producer squash no spill", o_busy, 0);
    nop();
    ck("R6", "producer squash no spill", o_busy, 0);
    mispredict(7);
    nop();
    ck("R6", "second producer squash no spill", o_sv, 0);

    cur_tag = "R7";
    commit(5, 0, 0);
    cap(12, 9, 'h77, 4, 1);
    mispredict(4);
    cur_tag = "R10";
    idle_in(); cap_valid = 1; cap_rob = 13; cmt_valid = 1; cmt_rob = 12; step();
    ck("R10", "capture ignored while busy", o_cap, 0);
    ck("R10", "commit ignored while busy", o_skip, 0);
    ck("R7", "first spill to ROB", o_tor, 1);
    ck("R7", "first spill slot", o_srob, 8);
    cur_tag = "R8";
    nop();
    ck("R8", "second spill in entry order", o_srob, 12);
    nop();
    ck("R8", "busy cleared", o_busy, 0);
    cur_tag = "R7";
    mispredict(2);
    nop();
    ck("R7", "committed producer spills to ARF", o_tor, 0);
    ck("R7", "ARF register", o_sareg, 2);

    cur_tag = "R9";
    cap(1, 10, 'h101, 5, 0);
    cap(2, 11, 'h202, 5, 0);
    cap(4, 12, 'h303, 5, 0);
    commit(1, 0, 0);
    idle_in(); intr_req = 1; step();
    nop();
    ck("R9", "drain spill to ARF", o_tor, 0);
    ck("R9", "drain first register", o_sareg, 10);
    nop(); nop();
    ck("R9", "drain last data", o_sdata, 'h303);
    nop();
    ck("R9", "drain done", o_busy, 0);
    cap(1, 1, 1, 0, 0); cap(2, 1, 1, 0, 0); cap(4, 1, 1, 0, 0); cap(6, 1, 1, 0, 0);
    ck("R9", "file empty after drain", o_cap, 1);
    nop();

    done = 1;
    summary();
    $finish;
  end

endmodule